// File: doc/BRIEF.md
# Floating-point status word and condition-code transfer unit

This block keeps the 16-bit status word of a stack-based floating-point unit. It holds the four condition-code bits, a sticky stack-fault bit and a sticky invalid-operation bit. It updates them from decoded operation strobes: stack overflow or underflow events, invalid-operand events, compare results, clear and initialise commands, save-state commands and environment restores. C1 is reused to record which kind of stack fault happened.

The block also models the only route by which the condition codes reach the integer flags. A store-status command first copies the status word into a 16-bit accumulator. A separate load-flags command then copies the accumulator's upper byte into the low byte of the integer flags register. After both steps, C0 sits on the carry position, C2 on the parity position and C3 on the zero position.

Top module: `fsw_flag_top`

## Requirements
- R1: While rst_ni is low, sw_o, acc_o and flags_o all read 0, and they stay 0 until a strobe changes them.
- R2: A stack overflow or underflow event sets bit 6 (stack fault) and bit 0 (invalid operation) of sw_o in the next cycle. It also sets C1 (bit 9) to 1 for overflow and 0 for underflow. If both events arrive together, they are treated as an overflow.
- R3: The stack-fault bit stays at 1 until an init, save, clear-exceptions or restore command arrives. An invalid-operand event, a compare or an idle cycle does not clear it.
- R4: An invalid-operand event without a stack fault sets bit 0 and leaves the stack-fault bit and the condition codes unchanged.
- R5: A compare writes C3 (bit 14), C2 (bit 10) and C0 (bit 8) from cmp_res_i[2], cmp_res_i[1] and cmp_res_i[0]. The encodings are greater 000, less 001, equal 100 and unordered 111. The compare clears C1 unless a stack fault arrives in the same cycle, in which case C1 records the fault kind.
- R6: An init or save command sets the whole status word to 0 in the next cycle.
- R7: A clear-exceptions command clears bits 6 and 0 and holds all four condition codes unchanged.
- R8: A restore command loads bits 14, 10, 9, 8, 6 and 0 of sw_o from the same bit positions of rstr_word_i.
- R9: When strobes collide, init/save wins over clear-exceptions, which wins over restore, which wins over fault, compare and invalid-operand events. A losing strobe has no effect.
- R10: A store-status command loads acc_o with the value sw_o had before the same clock edge. Without that command, acc_o holds its value.
- R11: A load-flags command loads flags_o with acc_o[15:8] as it stood before the edge, so C0 lands on bit 0, C2 on bit 2 and C3 on bit 6. Without that command, flags_o holds its value.
- R12: All bits of sw_o other than 14, 10, 9, 8, 6 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stk_ovf_i | input | 1 | Stack overflow event |
| stk_unf_i | input | 1 | Stack underflow event |
| inv_op_i | input | 1 | Invalid-operand event (not a stack fault) |
| cmp_i | input | 1 | Compare result valid |
| cmp_res_i | input | 3 | Compare outcome {C3,C2,C0} |
| init_i | input | 1 | Initialise command |
| save_i | input | 1 | Save-state command |
| clex_i | input | 1 | Clear-exceptions command |
| rstr_i | input | 1 | Environment restore command |
| rstr_word_i | input | 16 | Status word image for restore |
| stsw_i | input | 1 | Store status word into accumulator |
| ldfl_i | input | 1 | Load accumulator high byte into flags |
| sw_o | output | 16 | Status word |
| acc_o | output | 16 | Accumulator register |
| flags_o | output | 8 | Low byte of integer flags register |

## Verification
The properties assume that every strobe is a single-cycle pulse judged only at the clock edge. They also assume that cmp_res_i and rstr_word_i matter only in the cycle their strobe is high. Each property is gated on the resolved command, so colliding strobes never create conflicting expectations. The random stimulus fires each strobe independently with low probability, which produces collisions of every kind while keeping long idle stretches in which sticky bits must hold. Directed cases cover each compare encoding, simultaneous overflow and underflow, and a store-status in the same cycle as a status change.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  localparam int SW_W   = 16;
  localparam int FL_W   = 8;
  localparam int NCC    = 4;
  localparam int IE_BIT = 0;
  localparam int SF_BIT = 6;

  // condition code index -> status word bit
  function automatic int cc_pos(input int idx);
    case (idx)
      0:       return 8;
      1:       return 9;
      2:       return 10;
      default: return 14;
    endcase
  endfunction

  function automatic logic [SW_W-1:0] live_mask();
    logic [SW_W-1:0] m;
    m = '0;
    m[IE_BIT] = 1'b1;
    m[SF_BIT] = 1'b1;
    for (int i = 0; i < NCC; i++) m[cc_pos(i)] = 1'b1;
    return m;
  endfunction

  localparam logic [SW_W-1:0] SW_MASK = live_mask();

  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_CLR_ALL = 2'd1,
    OP_CLR_EXC = 2'd2,
    OP_RESTORE = 2'd3
  } ctl_op_e;
endpackage

// File: rtl/fsw_cmd_dec.sv
module fsw_cmd_dec
  import fsw_pkg::*;
(
  input  logic    init_i,
  input  logic    save_i,
  input  logic    clex_i,
  input  logic    rstr_i,
  input  logic    stk_ovf_i,
  input  logic    stk_unf_i,
  output ctl_op_e op_o,
  output logic    fault_o,
  output logic    fault_ovf_o
);
  always_comb begin
    if (init_i || save_i)  op_o = OP_CLR_ALL;
    else if (clex_i)       op_o = OP_CLR_EXC;
    else if (rstr_i)       op_o = OP_RESTORE;
    else                   op_o = OP_NONE;
  end

  assign fault_o     = stk_ovf_i | stk_unf_i;
  assign fault_ovf_o = stk_ovf_i;   // overflow dominates
endmodule

// File: rtl/fsw_status_reg.sv
module fsw_status_reg
  import fsw_pkg::*;
#(
  parameter int W = SW_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  ctl_op_e      op_i,
  input  logic         fault_i,
  input  logic         fault_ovf_i,
  input  logic         inv_i,
  input  logic         cmp_i,
  input  logic [2:0]   cmp_res_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] sw_o
);
  localparam int C0 = cc_pos(0);
  localparam int C1 = cc_pos(1);
  localparam int C2 = cc_pos(2);
  localparam int C3 = cc_pos(3);
  localparam logic [W-1:0] MASK = W'(SW_MASK);

  logic [W-1:0] sw_q, sw_d;

  always_comb begin
    sw_d = sw_q;
    unique case (op_i)
      OP_CLR_ALL: sw_d = '0;
      OP_CLR_EXC: begin
        sw_d[SF_BIT] = 1'b0;
        sw_d[IE_BIT] = 1'b0;
      end
      OP_RESTORE: sw_d = word_i;
      default: begin
        if (cmp_i) begin
          sw_d[C3] = cmp_res_i[2];
          sw_d[C2] = cmp_res_i[1];
          sw_d[C0] = cmp_res_i[0];
          sw_d[C1] = 1'b0;
        end
        if (fault_i) begin
          sw_d[SF_BIT] = 1'b1;
          sw_d[IE_BIT] = 1'b1;
          sw_d[C1]     = fault_ovf_i;
        end
        if (inv_i) sw_d[IE_BIT] = 1'b1;
      end
    endcase
    sw_d = sw_d & MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sw_q <= '0;
    else         sw_q <= sw_d;
  end

  assign sw_o = sw_q;

  AST_FAULT_SETS_SF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i && op_i == OP_NONE) |=> (sw_q[SF_BIT] && sw_q[IE_BIT])) else $error("sf"); // R2
  AST_FAULT_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i && op_i == OP_NONE) |=> (sw_q[C1] == $past(fault_ovf_i))) else $error("c1"); // R2
  AST_SF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_q[SF_BIT] && op_i == OP_NONE) |=> sw_q[SF_BIT]) else $error("sticky"); // R3
  AST_INV_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_i && !fault_i && !cmp_i && op_i == OP_NONE) |=>
    (sw_q[IE_BIT] && sw_q[SF_BIT] == $past(sw_q[SF_BIT]) &&
     {sw_q[C3], sw_q[C2], sw_q[C1], sw_q[C0]} == $past({sw_q[C3], sw_q[C2], sw_q[C1], sw_q[C0]})))
    else $error("inv"); // R4
  AST_CMP_CODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_i && op_i == OP_NONE) |=> ({sw_q[C3], sw_q[C2], sw_q[C0]} == $past(cmp_res_i)))
    else $error("cmp"); // R5
  AST_CLR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CLR_ALL) |=> (sw_q == '0)) else $error("clr"); // R6
  AST_CLEX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CLR_EXC) |=> (!sw_q[SF_BIT] && !sw_q[IE_BIT] &&
     {sw_q[C3], sw_q[C2], sw_q[C1], sw_q[C0]} == $past({sw_q[C3], sw_q[C2], sw_q[C1], sw_q[C0]})))
    else $error("clex"); // R7
  AST_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_RESTORE) |=> (sw_q == ($past(word_i) & MASK))) else $error("rstr"); // R8
endmodule

// File: rtl/fsw_xfer.sv
module fsw_xfer
  import fsw_pkg::*;
#(
  parameter int W  = SW_W,
  parameter int FW = FL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  sw_i,
  input  logic          stsw_i,
  input  logic          ldfl_i,
  output logic [W-1:0]  acc_o,
  output logic [FW-1:0] flags_o
);
  localparam int HI_LSB = W - FW;

  logic [W-1:0]  acc_q;
  logic [FW-1:0] fl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      fl_q  <= '0;
    end else begin
      if (stsw_i) acc_q <= sw_i;
      if (ldfl_i) fl_q  <= acc_q[W-1:HI_LSB];
    end
  end

  assign acc_o   = acc_q;
  assign flags_o = fl_q;

  AST_STORE_SW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stsw_i |=> (acc_q == $past(sw_i))) else $error("stsw"); // R10
  AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stsw_i |=> $stable(acc_q)) else $error("acc"); // R10
  AST_LOAD_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ldfl_i |=> (fl_q == $past(acc_q[W-1:HI_LSB]))) else $error("ldfl"); // R11
  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ldfl_i |=> $stable(fl_q)) else $error("fl"); // R11
endmodule

// File: rtl/fsw_flag_top.sv
module fsw_flag_top
  import fsw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stk_ovf_i,
  input  logic              stk_unf_i,
  input  logic              inv_op_i,
  input  logic              cmp_i,
  input  logic [2:0]        cmp_res_i,
  input  logic              init_i,
  input  logic              save_i,
  input  logic              clex_i,
  input  logic              rstr_i,
  input  logic [SW_W-1:0]   rstr_word_i,
  input  logic              stsw_i,
  input  logic              ldfl_i,
  output logic [SW_W-1:0]   sw_o,
  output logic [SW_W-1:0]   acc_o,
  output logic [FL_W-1:0]   flags_o
);
  ctl_op_e op;
  logic    fault, fault_ovf;
  logic [SW_W-1:0] sw;

  fsw_cmd_dec i_dec (
    .init_i      (init_i),
    .save_i      (save_i),
    .clex_i      (clex_i),
    .rstr_i      (rstr_i),
    .stk_ovf_i   (stk_ovf_i),
    .stk_unf_i   (stk_unf_i),
    .op_o        (op),
    .fault_o     (fault),
    .fault_ovf_o (fault_ovf)
  );

  fsw_status_reg #(.W(SW_W)) i_sreg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op),
    .fault_i     (fault),
    .fault_ovf_i (fault_ovf),
    .inv_i       (inv_op_i),
    .cmp_i       (cmp_i),
    .cmp_res_i   (cmp_res_i),
    .word_i      (rstr_word_i),
    .sw_o        (sw)
  );

  fsw_xfer #(.W(SW_W), .FW(FL_W)) i_xfer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sw_i    (sw),
    .stsw_i  (stsw_i),
    .ldfl_i  (ldfl_i),
    .acc_o   (acc_o),
    .flags_o (flags_o)
  );

  assign sw_o = sw;

  AST_DEAD_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rstr_i || init_i || save_i) |=> ((sw_o & ~SW_MASK) == '0)) else $error("dead"); // R12
  AST_INIT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((init_i || save_i) && (stk_ovf_i || stk_unf_i || rstr_i)) |=> !sw_o[SF_BIT])
    else $error("prio"); // R9
endmodule

// File: tb/test_fsw_flag_top.sv
`timescale 1ns/1ps
module test_fsw_flag_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic stk_ovf_i = 0, stk_unf_i = 0, inv_op_i = 0, cmp_i = 0;
  logic [2:0] cmp_res_i = '0;
  logic init_i = 0, save_i = 0, clex_i = 0, rstr_i = 0, stsw_i = 0, ldfl_i = 0;
  logic [15:0] rstr_word_i = '0;
  logic [15:0] sw_o, acc_o;
  logic [7:0]  flags_o;

  int total = 0, bad = 0;
  logic [15:0] e_sw = '0, e_acc = '0;
  logic [7:0]  e_fl = '0;
  localparam logic [15:0] LIVE = 16'h4741;

  always #10 clk = ~clk;

  fsw_flag_top i_fsw_flag_top (.clk_i(clk), .rst_ni(rst_ni), .stk_ovf_i(stk_ovf_i),
    .stk_unf_i(stk_unf_i), .inv_op_i(inv_op_i), .cmp_i(cmp_i), .cmp_res_i(cmp_res_i),
    .init_i(init_i), .save_i(save_i), .clex_i(clex_i), .rstr_i(rstr_i),
    .rstr_word_i(rstr_word_i), .stsw_i(stsw_i), .ldfl_i(ldfl_i),
    .sw_o(sw_o), .acc_o(acc_o), .flags_o(flags_o));

  function automatic logic [15:0] next_sw(input logic [15:0] s);
    logic [15:0] n;
    n = s;
    if (init_i || save_i) n = '0;
    else if (clex_i) begin n[6] = 0; n[0] = 0; end
    else if (rstr_i) n = rstr_word_i;
    else begin
      if (cmp_i) begin
        n[14] = cmp_res_i[2]; n[10] = cmp_res_i[1]; n[8] = cmp_res_i[0]; n[9] = 0;
      end
      if (stk_ovf_i || stk_unf_i) begin n[6] = 1; n[0] = 1; n[9] = stk_ovf_i; end
      if (inv_op_i) n[0] = 1;
    end
    return n & LIVE;
  endfunction

  task automatic check(input string tag, input string what, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic clear_in();
    {stk_ovf_i, stk_unf_i, inv_op_i, cmp_i, init_i, save_i, clex_i, rstr_i, stsw_i, ldfl_i} = '0;
    cmp_res_i = '0; rstr_word_i = '0;
  endtask

  // inputs set at negedge; one edge; compare at following negedge
  task automatic cycle(input string tag);
    logic [15:0] nsw, nacc; logic [7:0] nfl;
    nsw  = next_sw(e_sw);
    nacc = stsw_i ? e_sw : e_acc;
    nfl  = ldfl_i ? e_acc[15:8] : e_fl;
    @(posedge clk); @(negedge clk);
    e_sw = nsw; e_acc = nacc; e_fl = nfl;
    check(tag, "sw", sw_o, e_sw);
    check(tag, "acc", acc_o, e_acc);
    check(tag, "flags", {8'h0, flags_o}, {8'h0, e_fl});
    clear_in();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    repeat (3) @(negedge clk);
    check("R1", "sw", sw_o, 16'h0);
    check("R1", "acc", acc_o, 16'h0);
    rst_ni = 1'b1;
    cycle("R1");
    // R2 underflow
    stk_unf_i = 1; cycle("R2");
    check("R2", "unf", sw_o, 16'h0041);
    // R5 compare while SF set, then R3 sticky
    cmp_i = 1; cmp_res_i = 3'b100; cycle("R5");
    check("R3", "sticky", sw_o, 16'h4041);
    inv_op_i = 1; cycle("R4");
    check("R4", "inv", sw_o, 16'h4041);
    repeat (3) cycle("R3");
    check("R3", "idle", sw_o, 16'h4041);
    // R7 clear exceptions keeps CC
    clex_i = 1; cycle("R7");
    check("R7", "clex", sw_o, 16'h4000);
    inv_op_i = 1; cycle("R4");
    check("R4", "inv_only", sw_o, 16'h4001);
    // R2 overflow, and both at once
    stk_ovf_i = 1; cycle("R2");
    check("R2", "ovf", sw_o, 16'h4241);
    clex_i = 1; cycle("R7");
    stk_ovf_i = 1; stk_unf_i = 1; cycle("R2");
    check("R2", "both", sw_o, 16'h4241);
    // R5 each encoding, compare clears C1
    for (int k = 0; k < 4; k++) begin
      logic [2:0] codes [4] = '{3'b000, 3'b001, 3'b100, 3'b111};
      clex_i = 1; cycle("R7");
      cmp_i = 1; cmp_res_i = codes[k]; cycle("R5");
      check("R5", "code", sw_o, {1'b0, codes[k][2], 3'b0, codes[k][1], 1'b0, codes[k][0], 8'h00});
    end
    cmp_i = 1; cmp_res_i = 3'b001; stk_unf_i = 1; cycle("R5");
    check("R5", "cmp+unf", sw_o, 16'h0141);
    // R10/R11 two-step transfer: unordered -> C3,C2,C0
    init_i = 1; cycle("R6");
    check("R6", "init", sw_o, 16'h0);
    cmp_i = 1; cmp_res_i = 3'b111; cycle("R5");
    stsw_i = 1; cycle("R10");
    check("R10", "acc", acc_o, 16'h4500);
    ldfl_i = 1; cycle("R11");
    check("R11", "flags", {8'h0, flags_o}, 16'h0045);
    // R10 store same cycle as status change gets old value
    stsw_i = 1; stk_ovf_i = 1; cycle("R10");
    check("R10", "old", acc_o, 16'h4500);
    // R8 restore
    rstr_i = 1; rstr_word_i = 16'hFFFF; cycle("R8");
    check("R8", "all1", sw_o, 16'h4741);
    check("R12", "dead", sw_o & ~LIVE, 16'h0);
    rstr_i = 1; rstr_word_i = 16'hB2C1; cycle("R8");
    // R6 save
    save_i = 1; cycle("R6");
    check("R6", "save", sw_o, 16'h0);
    // R9 priorities
    stk_ovf_i = 1; init_i = 1; cmp_i = 1; cmp_res_i = 3'b111; cycle("R9");
    check("R9", "init>fault", sw_o, 16'h0);
    rstr_i = 1; rstr_word_i = 16'h0100; stk_ovf_i = 1; cycle("R9");
    check("R9", "rstr>fault", sw_o, 16'h0100);
    clex_i = 1; rstr_i = 1; rstr_word_i = 16'h4741; cycle("R9");
    check("R9", "clex>rstr", sw_o, 16'h0100);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      stk_ovf_i = ($urandom % 10) == 0;
      stk_unf_i = ($urandom % 10) == 0;
      inv_op_i  = ($urandom % 8) == 0;
      cmp_i     = ($urandom % 4) == 0;
      cmp_res_i = 3'($urandom);
      init_i    = ($urandom % 40) == 0;
      save_i    = ($urandom % 40) == 0;
      clex_i    = ($urandom % 20) == 0;
      rstr_i    = ($urandom % 25) == 0;
      rstr_word_i = 16'($urandom);
      stsw_i    = ($urandom % 4) == 0;
      ldfl_i    = ($urandom % 4) == 0;
      cycle("R9");
      check("R12", "dead", sw_o & ~LIVE, 16'h0);
    end
    // R1 asynchronous reset mid-run
    rst_ni = 1'b0; #3;
    e_sw = '0; e_acc = '0; e_fl = '0;
    check("R1", "sw", sw_o, 16'h0);
    check("R1", "acc", acc_o, 16'h0);
    check("R1", "flags", {8'h0, flags_o}, 16'h0);
    @(negedge clk); rst_ni = 1'b1;
    cycle("R1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule